// File: doc/BRIEF.md
# Combined-Transfer Read Responder for Block Process Call and Version Query

This block supplies the data bytes that a bus target returns in the read phase of a combined write-then-read transfer. A target front end latches the command byte and two configuration bytes of the write phase. It reports the bus events it sees: end of the write, repeated START, and STOP. It then asks for one byte per read request. The responder decides from the latched command and from the way the read phase was reached what each byte is.

Two partial commands produce a payload. The block process call (command code 3, first configuration byte equal to 1) arms a countdown reply. The reply is the count N from the second configuration byte, then N−1 down to 0. The version query (command code 4) arms a reply made of a short ASCII version text with a terminating NUL. A payload is given only when the read is joined to the write by a repeated START. A STOP clears the armed context. A read without a payload context returns a default status byte set by a parameter. Bus bit timing and acknowledge handling belong to the front end and are not part of this block.

Top module: `pcall_rsp`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `rd_valid` is 0 and `rd_byte` is 0x00.
- R2: A one-cycle `rd_req` gives `rd_valid` high in the next cycle, with the byte on `rd_byte`. `rd_valid` is never high without a request in the cycle before it.
- R3: After `cmd_load` with `cmd_byte` = 0x03 and `cfg_a` = 0x01, then `rep_start`, the first read byte equals N = `cfg_b`.
- R4: In that block process call reply, read k (k = 1..N, counted from 0) returns N − k, so the last payload byte is 0x00.
- R5: Reads past the end of the countdown (k > N) return 0x00.
- R6: Command 0x03 with `cfg_a` other than 0x01 arms nothing, and every read returns the default byte.
- R7: After `cmd_load` with `cmd_byte` = 0x04, then `rep_start`, the reads return the ASCII text "v3.1-rsp" ('v' = 0x76 first), then 0x00 (NUL), then 0x00 on every later read. The text plus NUL never exceeds 128 bytes.
- R8: Command 0x04 followed by `bus_stop` (a STOP and a fresh START instead of a repeated START) returns the default byte on every read.
- R9: `bus_stop` clears any armed or active reply, also in the middle of a payload. Later reads return the default byte until a new command is loaded and a repeated START follows.
- R10: A command code other than 0x03 or 0x04 returns the default byte, even after a repeated START.
- R11: With N = 0, the block process call reply is 0x00 (the length), followed only by 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_load | input | 1 | Pulse: the write phase ended and the command bytes are valid |
| cmd_byte | input | 8 | Latched command code |
| cfg_a | input | 8 | Latched first configuration byte |
| cfg_b | input | 8 | Latched second configuration byte (count N) |
| rep_start | input | 1 | Pulse: repeated START seen |
| bus_stop | input | 1 | Pulse: STOP seen |
| rd_req | input | 1 | Pulse: the front end needs the next read byte |
| rd_byte | output | 8 | Byte to transmit |
| rd_valid | output | 1 | `rd_byte` was updated for the last request |

## Verification
The bench goes after the two ways a read reaches its data. A design that treats a STOP-then-START like a repeated START would leak the version text where the default byte belongs. One that forgets to clear on STOP would keep counting down in the next transfer. At the countdown edges (N = 0, N = 255, and reads past the final zero), an off-by-one design gives one payload byte too many or too few, or wraps to 0xFF instead of holding 0x00. A design that skips the check on the first configuration byte answers a malformed block process call with a payload.

// File: rtl/pcall_pkg.sv
package pcall_pkg;

    localparam logic [7:0] CMD_BLK_CALL = 8'h03;
    localparam logic [7:0] CMD_VERSION  = 8'h04;
    localparam logic [7:0] BLK_ONE_MORE = 8'h01;

    localparam int         VER_LEN  = 8;
    localparam logic [VER_LEN*8-1:0] VER_TEXT = "v3.1-rsp";

    typedef enum logic [2:0] {
        CTX_IDLE,
        CTX_ARM_BLK,
        CTX_ARM_VER,
        CTX_RUN_BLK,
        CTX_RUN_VER
    } ctx_e;

    function automatic logic [7:0] ver_byte(input logic [15:0] idx);
        logic [7:0] r;
        r = 8'h00;
        for (int i = 0; i < VER_LEN; i++) begin
            if (idx == 16'(i)) r = VER_TEXT[(VER_LEN-1-i)*8 +: 8];
        end
        return r;
    endfunction

    function automatic logic [7:0] blk_byte(input logic [7:0] n, input logic [15:0] idx);
        logic [7:0] r;
        if (idx == 16'd0)             r = n;
        else if (idx <= {8'h00, n})   r = n - idx[7:0];
        else                          r = 8'h00;
        return r;
    endfunction

endpackage

// File: rtl/pcall_ctx.sv
module pcall_ctx
    import pcall_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_load,
    input  logic [7:0] cmd_byte,
    input  logic [7:0] cfg_a,
    input  logic [7:0] cfg_b,
    input  logic       rep_start,
    input  logic       bus_stop,
    output ctx_e       ctx,
    output logic [7:0] cnt_n
);
    ctx_e       ctx_d;
    logic [7:0] cnt_d;

    always_comb begin
        ctx_d = ctx;
        cnt_d = cnt_n;
        if (bus_stop) begin
            ctx_d = CTX_IDLE;
        end else if (cmd_load) begin
            cnt_d = cfg_b;
            if (cmd_byte == CMD_BLK_CALL && cfg_a == BLK_ONE_MORE)
                ctx_d = CTX_ARM_BLK;
            else if (cmd_byte == CMD_VERSION)
                ctx_d = CTX_ARM_VER;
            else
                ctx_d = CTX_IDLE;
        end else if (rep_start) begin
            case (ctx)
                CTX_ARM_BLK: ctx_d = CTX_RUN_BLK;
                CTX_ARM_VER: ctx_d = CTX_RUN_VER;
                default:     ctx_d = CTX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx   <= CTX_IDLE;
            cnt_n <= 8'h00;
        end else begin
            ctx   <= ctx_d;
            cnt_n <= cnt_d;
        end
    end
endmodule

// File: rtl/pcall_idx.sv
module pcall_idx #(
    parameter int IDX_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             adv,
    output logic [IDX_W-1:0] idx
);
    localparam logic [IDX_W-1:0] IDX_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst || clr)
            idx <= '0;
        else if (adv && idx != IDX_MAX)
            idx <= idx + 1'b1;
    end
endmodule

// File: rtl/pcall_gen.sv
module pcall_gen
    import pcall_pkg::*;
#(
    parameter int         IDX_W     = 9,
    parameter logic [7:0] DFLT_BYTE = 8'h00
) (
    input  ctx_e             ctx,
    input  logic [7:0]       cnt_n,
    input  logic [IDX_W-1:0] idx,
    output logic [7:0]       byte_o
);
    logic [15:0] idx_w;

    always_comb begin
        idx_w = '0;
        idx_w[IDX_W-1:0] = idx;
        case (ctx)
            CTX_RUN_BLK: byte_o = blk_byte(cnt_n, idx_w);
            CTX_RUN_VER: byte_o = ver_byte(idx_w);
            default:     byte_o = DFLT_BYTE;
        endcase
    end
endmodule

// File: rtl/pcall_rsp.sv
module pcall_rsp
    import pcall_pkg::*;
#(
    parameter int         IDX_W     = 9,
    parameter logic [7:0] DFLT_BYTE = 8'h00
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_load,
    input  logic [7:0] cmd_byte,
    input  logic [7:0] cfg_a,
    input  logic [7:0] cfg_b,
    input  logic       rep_start,
    input  logic       bus_stop,
    input  logic       rd_req,
    output logic [7:0] rd_byte,
    output logic       rd_valid
);
    ctx_e             ctx_q;
    logic [7:0]       cnt_n;
    logic [IDX_W-1:0] idx_q;
    logic [7:0]       next_byte;
    logic             idx_clr;

    assign idx_clr = cmd_load | rep_start | bus_stop;

    pcall_ctx u_ctx (
        .clk(clk), .rst(rst), .cmd_load(cmd_load), .cmd_byte(cmd_byte),
        .cfg_a(cfg_a), .cfg_b(cfg_b), .rep_start(rep_start),
        .bus_stop(bus_stop), .ctx(ctx_q), .cnt_n(cnt_n)
    );

    pcall_idx #(.IDX_W(IDX_W)) u_idx (
        .clk(clk), .rst(rst), .clr(idx_clr), .adv(rd_req), .idx(idx_q)
    );

    pcall_gen #(.IDX_W(IDX_W), .DFLT_BYTE(DFLT_BYTE)) u_gen (
        .ctx(ctx_q), .cnt_n(cnt_n), .idx(idx_q), .byte_o(next_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_byte  <= 8'h00;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_req;
            if (rd_req) rd_byte <= next_byte;
        end
    end
endmodule

// File: rtl/pcall_chk.sv
module pcall_chk
    import pcall_pkg::*;
#(
    parameter int IDX_W = 9
) (
    input logic             clk,
    input logic             rst,
    input logic             rd_req,
    input logic             rd_valid,
    input logic [7:0]       rd_byte,
    input logic             rep_start,
    input logic             bus_stop,
    input logic             cmd_load,
    input ctx_e             ctx,
    input logic [IDX_W-1:0] idx,
    input logic [7:0]       cnt_n
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!rd_valid && rd_byte == 8'h00));

    assert_req_answered_R2: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> rd_valid);

    assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(rd_req));

    assert_rstart_runs_blk_R3: assert property (@(posedge clk) disable iff (rst)
        (rep_start && !bus_stop && !cmd_load && ctx == CTX_ARM_BLK)
        |=> (ctx == CTX_RUN_BLK && idx == '0));

    assert_tail_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !cmd_load && !rep_start && !bus_stop && ctx == CTX_RUN_BLK
         && idx > IDX_W'(cnt_n))
        |=> (rd_byte == 8'h00));

    assert_stop_clears_R9: assert property (@(posedge clk) disable iff (rst)
        bus_stop |=> (ctx == CTX_IDLE));
endmodule

bind pcall_rsp pcall_chk #(.IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst(rst), .rd_req(rd_req), .rd_valid(rd_valid),
    .rd_byte(rd_byte), .rep_start(rep_start), .bus_stop(bus_stop),
    .cmd_load(cmd_load), .ctx(ctx_q), .idx(idx_q), .cnt_n(cnt_n)
);

// File: tb/pcall_rsp_tb.sv
module pcall_rsp_tb;
    localparam int         CLK_PER = 10;
    localparam logic [7:0] DFLT    = 8'h5A;
    localparam logic [63:0] VER_EXP = "v3.1-rsp";

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_load = 1'b0, rep_start = 1'b0, bus_stop = 1'b0, rd_req = 1'b0;
    logic [7:0] cmd_byte = 8'h00, cfg_a = 8'h00, cfg_b = 8'h00;
    logic [7:0] rd_byte;
    logic       rd_valid;

    int checks = 0;
    int errors = 0;

    always #(CLK_PER/2) clk = ~clk;

    pcall_rsp #(.IDX_W(9), .DFLT_BYTE(DFLT)) u_dut (
        .clk(clk), .rst(rst), .cmd_load(cmd_load), .cmd_byte(cmd_byte),
        .cfg_a(cfg_a), .cfg_b(cfg_b), .rep_start(rep_start),
        .bus_stop(bus_stop), .rd_req(rd_req), .rd_byte(rd_byte),
        .rd_valid(rd_valid)
    );

    // scenario: {cmd, cfg_a, cfg_b, joined by repeated START}
    localparam logic [24:0] SCN [0:5] = '{
        {8'h03, 8'h01, 8'h10, 1'b1},   // R3 R4 R5
        {8'h03, 8'h02, 8'h10, 1'b1},   // R6
        {8'h04, 8'h00, 8'h00, 1'b1},   // R7
        {8'h04, 8'h00, 8'h00, 1'b0},   // R8
        {8'h07, 8'h01, 8'h05, 1'b1},   // R10
        {8'h03, 8'h01, 8'h05, 1'b0}    // R9
    };

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    task automatic load(input logic [7:0] c, input logic [7:0] a, input logic [7:0] b);
        @(negedge clk);
        cmd_byte = c; cfg_a = a; cfg_b = b; cmd_load = 1'b1;
        @(negedge clk);
        cmd_load = 1'b0;
    endtask

    task automatic pulse_rep();
        @(negedge clk); rep_start = 1'b1;
        @(negedge clk); rep_start = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk); bus_stop = 1'b1;
        @(negedge clk); bus_stop = 1'b0;
    endtask

    task automatic read_chk(input string tag, input logic [7:0] exp);
        @(negedge clk); rd_req = 1'b1;
        @(negedge clk); rd_req = 1'b0;
        check8("R2 valid", {7'd0, rd_valid}, 8'h01);
        check8(tag, rd_byte, exp);
    endtask

    function automatic logic [7:0] ver_exp(input int k);
        if (k < 8) return VER_EXP[(7-k)*8 +: 8];
        return 8'h00;
    endfunction

    function automatic logic [7:0] blk_exp(input logic [7:0] n, input int k);
        if (k == 0) return n;
        if (k <= int'(n)) return 8'(int'(n) - k);
        return 8'h00;
    endfunction

    initial begin
        #(CLK_PER * 200000);
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check8("R1 valid in reset", {7'd0, rd_valid}, 8'h00);
        check8("R1 byte in reset", rd_byte, 8'h00);
        rst = 1'b0;
        @(negedge clk);
        check8("R1 valid after reset", {7'd0, rd_valid}, 8'h00);

        foreach (SCN[s]) begin
            logic [7:0] c, a, b;
            logic       rep;
            {c, a, b, rep} = SCN[s];
            load(c, a, b);
            if (rep) pulse_rep(); else pulse_stop();
            for (int k = 0; k < 20; k++) begin
                if (rep && c == 8'h03 && a == 8'h01)
                    read_chk(k == 0 ? "R3" : (k <= int'(b) ? "R4" : "R5"), blk_exp(b, k));
                else if (rep && c == 8'h04)
                    read_chk("R7", ver_exp(k));
                else if (!rep && c == 8'h04)
                    read_chk("R8", DFLT);
                else if (!rep)
                    read_chk("R9", DFLT);
                else if (c == 8'h03)
                    read_chk("R6", DFLT);
                else
                    read_chk("R10", DFLT);
            end
            pulse_stop();
        end

        // R2: valid drops when no request follows
        @(negedge clk);
        check8("R2 idle valid", {7'd0, rd_valid}, 8'h00);

        // R11: zero count
        load(8'h03, 8'h01, 8'h00); pulse_rep();
        read_chk("R11 length", 8'h00);
        read_chk("R11 tail", 8'h00);
        read_chk("R11 tail", 8'h00);
        pulse_stop();

        // R4/R5: full count 255
        load(8'h03, 8'h01, 8'hFF); pulse_rep();
        for (int k = 0; k < 258; k++)
            read_chk(k == 0 ? "R3 max" : (k <= 255 ? "R4 max" : "R5 max"), blk_exp(8'hFF, k));
        pulse_stop();

        // R9: STOP in the middle of a payload
        load(8'h03, 8'h01, 8'h08); pulse_rep();
        read_chk("R3 mid", 8'h08);
        read_chk("R4 mid", 8'h07);
        pulse_stop();
        read_chk("R9 after stop", DFLT);
        pulse_rep();
        read_chk("R9 rstart without command", DFLT);
        pulse_stop();

        // R7: version text then NUL, read again fresh
        load(8'h04, 8'hAA, 8'h55); pulse_rep();
        read_chk("R7 first char", 8'h76);
        pulse_stop();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule